// File: doc/BRIEF.md
# Programmable panel display timing generator

This block produces the horizontal sync, vertical sync and display-enable (DE) signals for a flat panel. It runs on the panel pixel clock and takes its timing from a set of 16-bit programmed values. A pixel counter and a line counter measure every position from the leading edge of that axis's own sync pulse. The sync width, the active-window start and the active-window end are all offsets from that edge.

Each output sync has its own programmable polarity. The vertical total is taken from two separate values, one for odd frames and one for even frames. The generator alternates between them frame by frame, so equal values give frames of fixed length. A control bit selects the pixel-clock edge on which panel data is launched. Another control bit turns the pixel clock into a gated clock that runs only while DE is active.

New programmed values are copied into working copies only at a frame boundary, so no frame mixes old and new timing. An even horizontal active start is an invalid setting and is reported on a separate error output.

A small state machine sequences the frames:

| State | Meaning |
|---|---|
| FR_LOAD | Entered during reset. Counters are held at zero and outputs are idle. The programmed values are captured. |
| FR_ODD | An odd frame is running, and the odd vertical total applies. |
| FR_EVEN | An even frame is running, and the even vertical total applies. |

| Transition | Condition |
|---|---|
| FR_LOAD → FR_ODD | Always, on the first clock after reset is released. |
| FR_ODD → FR_EVEN | On the last pixel of the last line of the frame. |
| FR_EVEN → FR_ODD | On the last pixel of the last line of the frame. |

Top module: `panel_timing_gen`

## Requirements
- R1: `pix_cnt` counts 0 to `h_total`−1 and then returns to 0. `line_cnt` advances by one each time `pix_cnt` wraps.
- R2: `line_cnt` counts 0 to V−1. V is `v_total_odd` in odd frames and `v_total_even` in even frames. The first frame after reset is odd, and frames alternate odd/even after that.
- R3: The horizontal sync pulse is active while `pix_cnt` < `h_sync_w`. The vertical sync pulse is active while `line_cnt` < `v_sync_w`.
- R4: `ctrl[0]` sets the hsync polarity and `ctrl[1]` sets the vsync polarity:
  - A bit value of 1 makes that sync pin high while active and low otherwise.
  - A bit value of 0 makes the pin low while active and high when idle (active-low).
- R5: `de` is high exactly when `h_act_start` ≤ `pix_cnt` < `h_act_end` and `v_act_start` ≤ `line_cnt` < `v_act_end`.
- R6: With `ctrl[2]`=1, `pclk_en` equals `de`. With `ctrl[2]`=0, `pclk_en` is constantly 1.
- R7: `data_on_fall` follows `ctrl[3]`. A value of 1 means panel data is launched on the falling pixel-clock edge, and 0 means the rising edge.
- R8: `cfg_err` is high in the same cycle whenever `h_act_start[0]` is 0 (an even start value), and low otherwise.
- R9: Changes to any timing value or to `ctrl` take effect only from the first pixel of the next frame. The frame already running keeps its old timing, polarity, gating and edge selection.
- R10: During reset, all outputs are idle:
  - `pix_cnt` and `line_cnt` are 0.
  - `de` is 0.
  - `hsync` and `vsync` are 1.
  - `pclk_en` is 1 and `data_on_fall` is 0.

  After reset is released, the first clock edge loads the programmed values. The next sample shows the first odd frame at pixel 0, line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_total | input | 16 | Pixels per line |
| h_sync_w | input | 16 | Hsync pulse width in pixels |
| h_act_start | input | 16 | First active pixel, counted from hsync leading edge (must be odd) |
| h_act_end | input | 16 | End of active pixels (exclusive), counted from hsync leading edge |
| v_sync_w | input | 16 | Vsync pulse width in lines |
| v_act_start | input | 16 | First active line, counted from vsync leading edge |
| v_act_end | input | 16 | End of active lines (exclusive), counted from vsync leading edge |
| v_total_odd | input | 16 | Lines in odd frames |
| v_total_even | input | 16 | Lines in even frames |
| ctrl | input | 4 | [0] hsync polarity, [1] vsync polarity, [2] clock gating, [3] falling-edge launch |
| hsync | output | 1 | Horizontal sync pin |
| vsync | output | 1 | Vertical sync pin |
| de | output | 1 | Display enable |
| pclk_en | output | 1 | Pixel clock enable for the panel clock |
| data_on_fall | output | 1 | Launch-edge select in force for the current frame |
| pix_cnt | output | 16 | Pixel position from hsync leading edge |
| line_cnt | output | 16 | Line position from vsync leading edge |
| cfg_err | output | 1 | Even horizontal active start programmed |

## Verification
The assertions check several properties on every cycle:
- Each counter stays below its terminal count, steps by one and wraps to zero after its last value.
- The frame state leaves FR_LOAD for FR_ODD and toggles parity only at the last pixel of a frame.
- The working copies of the timing values stay frozen inside a frame.
- DE only rises at the programmed horizontal start.

The exact pixel-by-pixel waveform of sync pins, DE and clock enable can only be shown by the bench's scenarios. The same holds for the polarity mapping, the alternation of odd and even frame lengths, and the deferral of mid-frame register writes to the next frame.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
    localparam int PTG_CW     = 16;
    localparam int PTG_CTRL_W = 4;
    localparam int CTL_HPOL   = 0;
    localparam int CTL_VPOL   = 1;
    localparam int CTL_GATE   = 2;
    localparam int CTL_FALL   = 3;

    typedef enum logic [1:0] {
        FR_LOAD = 2'd0,
        FR_ODD  = 2'd1,
        FR_EVEN = 2'd2
    } frame_st_t;

    typedef struct packed {
        logic [PTG_CW-1:0]     h_total;
        logic [PTG_CW-1:0]     h_sync;
        logic [PTG_CW-1:0]     h_start;
        logic [PTG_CW-1:0]     h_end;
        logic [PTG_CW-1:0]     v_sync;
        logic [PTG_CW-1:0]     v_start;
        logic [PTG_CW-1:0]     v_end;
        logic [PTG_CW-1:0]     v_tot_odd;
        logic [PTG_CW-1:0]     v_tot_even;
        logic [PTG_CTRL_W-1:0] ctrl;
    } ptg_cfg_t;
endpackage

// File: rtl/ptg_wrap_ctr.sv
module ptg_wrap_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         adv,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt,
    output logic         last
);
    localparam logic [W:0] ONE = (W+1)'(1);

    logic [W:0] cnt_inc;

    assign cnt_inc = {1'b0, cnt} + ONE;
    assign last    = (cnt_inc >= {1'b0, limit});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (hold) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= last ? '0 : cnt_inc[W-1:0];
        end
    end

    // R1 / R2: counter never reaches its terminal count
    a_r1_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (limit != '0) |-> (cnt < limit));

    // R1 / R2: wrap after the last value
    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && adv && last) |=> (cnt == '0));

    // R1 / R2: single step otherwise
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && adv && !last) |=> (cnt == $past(cnt) + W'(1)));
endmodule

// File: rtl/ptg_frame_ctl.sv
module ptg_frame_ctl
    import ptg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  ptg_cfg_t            cfg_in,
    input  logic                frame_end,
    output frame_st_t           state,
    output ptg_cfg_t            cfg_act,
    output logic                hold,
    output logic [PTG_CW-1:0]   v_limit
);
    frame_st_t nxt;
    logic      load_now;

    always_comb begin
        nxt = state;
        unique case (state)
            FR_LOAD: nxt = FR_ODD;
            FR_ODD:  nxt = frame_end ? FR_EVEN : FR_ODD;
            FR_EVEN: nxt = frame_end ? FR_ODD : FR_EVEN;
            default: nxt = FR_LOAD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FR_LOAD;
        else        state <= nxt;
    end

    assign load_now = (state == FR_LOAD) || frame_end;

    // working copy of the programmed timing, refreshed at frame boundaries
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cfg_act <= '0;
        else if (load_now) cfg_act <= cfg_in;
    end

    // outputs of the state machine
    always_comb begin
        hold    = (state == FR_LOAD);
        v_limit = (state == FR_EVEN) ? cfg_act.v_tot_even : cfg_act.v_tot_odd;
    end

    // R10: single load cycle, then the first frame is odd
    a_r10_load_then_odd: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FR_LOAD) |=> (state == FR_ODD));

    // R2: odd frame is followed by even frame
    a_r2_odd_to_even: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FR_ODD && frame_end) |=> (state == FR_EVEN));

    // R2: parity changes only at the frame end
    a_r2_parity_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != FR_LOAD && !frame_end) |=> $stable(state));

    // R9: working timing frozen within a frame
    a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != FR_LOAD && !frame_end) |=> $stable(cfg_act));
endmodule

// File: rtl/ptg_out_stage.sv
module ptg_out_stage
    import ptg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  ptg_cfg_t          cfg,
    input  logic [PTG_CW-1:0] h_cnt,
    input  logic [PTG_CW-1:0] v_cnt,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic              pclk_en,
    output logic              data_on_fall
);
    logic running, hs_act, vs_act, h_win, v_win;

    always_comb begin
        running      = !hold;
        hs_act       = running && (h_cnt < cfg.h_sync);
        vs_act       = running && (v_cnt < cfg.v_sync);
        h_win        = (h_cnt >= cfg.h_start) && (h_cnt < cfg.h_end);
        v_win        = (v_cnt >= cfg.v_start) && (v_cnt < cfg.v_end);
        de           = running && h_win && v_win;
        hsync        = hs_act ~^ cfg.ctrl[CTL_HPOL];
        vsync        = vs_act ~^ cfg.ctrl[CTL_VPOL];
        pclk_en      = !cfg.ctrl[CTL_GATE] || de;
        data_on_fall = cfg.ctrl[CTL_FALL];
    end

    // R5: the active window opens only at the programmed horizontal start
    a_r5_de_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(de) |-> (h_cnt == cfg.h_start));
endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen
    import ptg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PTG_CW-1:0]     h_total,
    input  logic [PTG_CW-1:0]     h_sync_w,
    input  logic [PTG_CW-1:0]     h_act_start,
    input  logic [PTG_CW-1:0]     h_act_end,
    input  logic [PTG_CW-1:0]     v_sync_w,
    input  logic [PTG_CW-1:0]     v_act_start,
    input  logic [PTG_CW-1:0]     v_act_end,
    input  logic [PTG_CW-1:0]     v_total_odd,
    input  logic [PTG_CW-1:0]     v_total_even,
    input  logic [PTG_CTRL_W-1:0] ctrl,
    output logic                  hsync,
    output logic                  vsync,
    output logic                  de,
    output logic                  pclk_en,
    output logic                  data_on_fall,
    output logic [PTG_CW-1:0]     pix_cnt,
    output logic [PTG_CW-1:0]     line_cnt,
    output logic                  cfg_err
);
    ptg_cfg_t          cfg_in, cfg_act;
    frame_st_t         state;
    logic              hold, h_last, v_last, frame_end;
    logic [PTG_CW-1:0] v_limit;

    always_comb begin
        cfg_in.h_total    = h_total;
        cfg_in.h_sync     = h_sync_w;
        cfg_in.h_start    = h_act_start;
        cfg_in.h_end      = h_act_end;
        cfg_in.v_sync     = v_sync_w;
        cfg_in.v_start    = v_act_start;
        cfg_in.v_end      = v_act_end;
        cfg_in.v_tot_odd  = v_total_odd;
        cfg_in.v_tot_even = v_total_even;
        cfg_in.ctrl       = ctrl;
    end

    assign frame_end = h_last && v_last && !hold;
    assign cfg_err   = !h_act_start[0];

    ptg_frame_ctl u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_in    (cfg_in),
        .frame_end (frame_end),
        .state     (state),
        .cfg_act   (cfg_act),
        .hold      (hold),
        .v_limit   (v_limit)
    );

    ptg_wrap_ctr #(.W(PTG_CW)) u_hctr (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (hold),
        .adv   (1'b1),
        .limit (cfg_act.h_total),
        .cnt   (pix_cnt),
        .last  (h_last)
    );

    ptg_wrap_ctr #(.W(PTG_CW)) u_vctr (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (hold),
        .adv   (h_last),
        .limit (v_limit),
        .cnt   (line_cnt),
        .last  (v_last)
    );

    ptg_out_stage u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .hold         (hold),
        .cfg          (cfg_act),
        .h_cnt        (pix_cnt),
        .v_cnt        (line_cnt),
        .hsync        (hsync),
        .vsync        (vsync),
        .de           (de),
        .pclk_en      (pclk_en),
        .data_on_fall (data_on_fall)
    );

    // R1: line counter only moves when the pixel counter wraps
    a_r1_line_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !h_last) |=> $stable(line_cnt));
endmodule

// File: tb/panel_timing_gen_tb.sv
module panel_timing_gen_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] r_htot, r_hsw, r_hs, r_he, r_vsw, r_vs, r_ve, r_vto, r_vte;
    logic [3:0]  r_ctrl;
    logic        hsync, vsync, de, pclk_en, data_on_fall, cfg_err;
    logic [15:0] pix_cnt, line_cnt;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    panel_timing_gen u_dut (
        .clk (clk), .rst_n (rst_n),
        .h_total (r_htot), .h_sync_w (r_hsw), .h_act_start (r_hs), .h_act_end (r_he),
        .v_sync_w (r_vsw), .v_act_start (r_vs), .v_act_end (r_ve),
        .v_total_odd (r_vto), .v_total_even (r_vte), .ctrl (r_ctrl),
        .hsync (hsync), .vsync (vsync), .de (de), .pclk_en (pclk_en),
        .data_on_fall (data_on_fall), .pix_cnt (pix_cnt), .line_cnt (line_cnt),
        .cfg_err (cfg_err)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", what, act, exp, $time);
        end
    endtask

    // advance one clock and sample away from the edge
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic cfg_a();
        r_htot = 16'd12; r_hsw = 16'd2; r_hs = 16'd3; r_he = 16'd9;
        r_vsw = 16'd1; r_vs = 16'd2; r_ve = 16'd5; r_vto = 16'd7; r_vte = 16'd8;
        r_ctrl = 4'b0000;
    endtask

    task automatic cfg_b();
        r_htot = 16'd10; r_hsw = 16'd3; r_hs = 16'd1; r_he = 16'd6;
        r_vsw = 16'd2; r_vs = 16'd1; r_ve = 16'd4; r_vto = 16'd5; r_vte = 16'd6;
        r_ctrl = 4'b0111;
    endtask

    // R10: idle outputs during reset and in the load cycle
    task automatic t_reset();
        rst_n = 1'b0;
        cfg_a();
        repeat (3) tick();
        chk(32'(hsync), 32'd1, "R10 hsync idle in reset");
        chk(32'(vsync), 32'd1, "R10 vsync idle in reset");
        chk(32'(de), 32'd0, "R10 de low in reset");
        chk(32'(pclk_en), 32'd1, "R10 pclk_en in reset");
        chk(32'(data_on_fall), 32'd0, "R10 data_on_fall in reset");
        chk(32'(pix_cnt), 32'd0, "R10 pix_cnt in reset");
        chk(32'(line_cnt), 32'd0, "R10 line_cnt in reset");
        rst_n = 1'b1;
        chk(32'(hsync), 32'd1, "R10 hsync idle before load edge");
        tick();
    endtask

    // Scan one whole frame; R1 R2 R3 R4 R5 R6 R7 R9 checked per pixel.
    // chg: 0 none, 1 switch to config B at chg_at, 2 set ctrl[3] at chg_at
    task automatic scan_frame(input int ht, input int hsw, input int hs, input int he,
                              input int vsw, input int vs, input int ve, input int vt,
                              input logic [3:0] ctl, input int chg, input int chg_at,
                              input string tag);
        for (int k = 0; k < ht*vt; k++) begin
            int  p    = k % ht;
            int  l    = k / ht;
            bit  hact = (p < hsw);
            bit  vact = (l < vsw);
            bit  dexp = (p >= hs) && (p < he) && (l >= vs) && (l < ve);
            bit  hpin = ctl[0] ? hact : !hact;
            bit  vpin = ctl[1] ? vact : !vact;
            bit  pen  = ctl[2] ? dexp : 1'b1;
            chk(32'(pix_cnt), 32'(p), {tag, " R1 pix_cnt"});
            chk(32'(line_cnt), 32'(l), {tag, " R2 line_cnt"});
            chk(32'(hsync), 32'(hpin), {tag, " R3 R4 hsync"});
            chk(32'(vsync), 32'(vpin), {tag, " R3 R4 vsync"});
            chk(32'(de), 32'(dexp), {tag, " R5 de"});
            chk(32'(pclk_en), 32'(pen), {tag, " R6 pclk_en"});
            chk(32'(data_on_fall), 32'(ctl[3]), {tag, " R7 R9 data_on_fall"});
            if (k == chg_at) begin
                if (chg == 1) cfg_b();
                else if (chg == 2) r_ctrl = 4'b1111;
            end
            tick();
        end
    endtask

    // R8: error flag on even horizontal start
    task automatic t_cfg_err();
        chk(32'(cfg_err), 32'd0, "R8 odd start no error");
        r_hs = 16'd2;
        #1;
        chk(32'(cfg_err), 32'd1, "R8 even start flagged");
        r_hs = 16'd1;
        #1;
        chk(32'(cfg_err), 32'd0, "R8 error clears on odd start");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        // frame 1 odd: config A stays in force despite mid-frame write (R9)
        scan_frame(12, 2, 3, 9, 1, 2, 5, 7, 4'b0000, 1, 20, "F1 odd");
        // frame 2 even: config B, active-high syncs, gated clock
        scan_frame(10, 3, 1, 6, 2, 1, 4, 6, 4'b0111, 2, 5, "F2 even");
        // frame 3 odd: falling-edge launch now applies
        scan_frame(10, 3, 1, 6, 2, 1, 4, 5, 4'b1111, 0, -1, "F3 odd");
        // frame 4 even again: alternation continues
        scan_frame(10, 3, 1, 6, 2, 1, 4, 6, 4'b1111, 0, -1, "F4 even");
        t_cfg_err();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule